// File: doc/BRIEF.md
# Stereo Soft Mute Ramp with Silence Flag

The block sits in the sample path of a stereo audio converter, after the serial audio receiver. When the mute request rises, it lowers the gain on both channels to silence in equal steps. When the request falls, it raises the gain back to unity in the same way. A ramp is atomic: once it has started, the block watches neither edge of the request until the ramp ends. At that point it reads the request level again.

A separate detector counts consecutive sample strobes on which both channels carry all-zero data. It raises a flag once the run reaches a length of about 350 ms at a 44.1 kHz sample rate. The detector looks at the incoming samples, not the scaled ones, so muting by itself never signals silence.

Top module: `soft_mute_zdet`

## Requirements
- R1: After reset the gain is unity (64/64): `busy_o`, `zero_o` and `valid_o` are low, and the first strobed sample comes out unchanged.
- R2: With the gain at unity and no ramp running, a high `mute_i` starts a downward ramp on the next clock. The gain drops by one step after every 16 strobes and reaches 0 after exactly 1024 strobes, which is about 23 ms at 44.1 kHz.
- R3: Each output sample is (input × gain) arithmetically shifted right by 6, with gain in 0..64. It appears one clock after the strobe, `valid_o` is high for exactly that clock, and the output holds its value between strobes.
- R4: `busy_o` is high from the clock after a ramp starts until the strobe that completes the 64th step, and it is low otherwise.
- R5: With the gain at 0 and no ramp running, a low `mute_i` starts an upward ramp with the same step timing. After 512 strobes the gain is 32/64, and after 1024 strobes it is unity.
- R6: Request changes during a ramp are ignored. A ramp always runs to its end point. A request that differs from the reached level when the ramp ends starts the opposite ramp on the next clock.
- R7: `zero_o` rises on the clock after the 15435th consecutive strobe on which both channels are zero. It stays high while further zero strobes arrive, because the count saturates.
- R8: A strobe with a non-zero sample on either channel clears the silence count, and `zero_o` is low on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | One-clock strobe per stereo sample |
| left_i | input | 16 | Left sample, two's complement |
| right_i | input | 16 | Right sample, two's complement |
| mute_i | input | 1 | Mute request level |
| left_o | output | 16 | Scaled left sample |
| right_o | output | 16 | Scaled right sample |
| valid_o | output | 1 | Scaled sample strobe |
| zero_o | output | 1 | Both channels silent for the full window |
| busy_o | output | 1 | Gain ramp in progress |

## Verification
The bench toggles the request in the middle of a ramp, both as a brief glitch and as a held level. A design that reacted to these changes would reverse direction or stall, and a design that forgot the held level would never start the follow-up ramp. It checks the exact strobe at which the silence flag rises and confirms the flag stays high afterwards. An off-by-one count would show the flag one strobe early or late, and a count that wrapped instead of saturating would drop the flag. It also clears the count with a non-zero value on each channel separately, then sends one strobe short of the full window. A detector that watched only one channel, or that kept a partial count across the clear, would raise the flag too early. The extreme sample values at unity gain, together with the mid-ramp half-gain value, catch a wrong shift amount or a logical shift used in place of an arithmetic one.

// File: rtl/smz_pkg.sv
package smz_pkg;
  typedef enum logic [1:0] {
    RAMP_IDLE = 2'd0,
    RAMP_DOWN = 2'd1,
    RAMP_UP   = 2'd2
  } ramp_state_e;
endpackage

// File: rtl/smz_ramp.sv
module smz_ramp
  import smz_pkg::*;
#(
  parameter int STEPS = 64,
  parameter int SPS   = 16,
  localparam int GW   = $clog2(STEPS + 1),
  localparam int SW   = (SPS > 1) ? $clog2(SPS) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic          mute_i,
  output logic [GW-1:0] gain_o,
  output logic          busy_o
);
  localparam logic [GW-1:0] G_MAX = GW'(STEPS);
  localparam logic [SW-1:0] S_LAST = SW'(SPS - 1);

  ramp_state_e   state_q;
  logic [GW-1:0] gain_q;
  logic [SW-1:0] sub_q;
  logic [GW-1:0] gain_nx;

  assign gain_nx = (state_q == RAMP_DOWN) ? gain_q - 1'b1 : gain_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RAMP_IDLE;
      gain_q  <= G_MAX;
      sub_q   <= '0;
    end else if (state_q == RAMP_IDLE) begin
      // request is sampled only between ramps
      if (mute_i && gain_q == G_MAX) begin
        state_q <= RAMP_DOWN;
        sub_q   <= '0;
      end else if (!mute_i && gain_q == '0) begin
        state_q <= RAMP_UP;
        sub_q   <= '0;
      end
    end else if (valid_i) begin
      if (sub_q == S_LAST) begin
        sub_q  <= '0;
        gain_q <= gain_nx;
        if (gain_nx == '0 || gain_nx == G_MAX) state_q <= RAMP_IDLE;
      end else begin
        sub_q <= sub_q + 1'b1;
      end
    end
  end

  assign gain_o = gain_q;
  assign busy_o = (state_q != RAMP_IDLE);
endmodule

// File: rtl/smz_scale.sv
module smz_scale #(
  parameter int DW    = 16,
  parameter int STEPS = 64,
  localparam int GW   = $clog2(STEPS + 1),
  localparam int SH   = $clog2(STEPS),
  localparam int PW   = DW + GW + 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic        [GW-1:0] gain_i,
  input  logic signed [DW-1:0] sample_i,
  output logic signed [DW-1:0] sample_o
);
  logic signed [PW-1:0] prod;

  assign prod = sample_i * $signed({1'b0, gain_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sample_o <= '0;
    else if (valid_i) sample_o <= prod[SH +: DW];
  end
endmodule

// File: rtl/smz_silence.sv
module smz_silence #(
  parameter int DW    = 16,
  parameter int LIMIT = 15435,
  localparam int CW   = $clog2(LIMIT + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [DW-1:0] left_i,
  input  logic [DW-1:0] right_i,
  output logic          zero_o
);
  localparam logic [CW-1:0] C_MAX = CW'(LIMIT);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (valid_i) begin
      if (|left_i || |right_i) cnt_q <= '0;
      else if (cnt_q != C_MAX) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign zero_o = (cnt_q == C_MAX);
endmodule

// File: rtl/soft_mute_zdet.sv
module soft_mute_zdet #(
  parameter int DW         = 16,
  parameter int STEPS      = 64,
  parameter int SPS        = 16,
  parameter int ZERO_LIMIT = 15435,
  localparam int GW        = $clog2(STEPS + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic signed [DW-1:0] left_i,
  input  logic signed [DW-1:0] right_i,
  input  logic                 mute_i,
  output logic signed [DW-1:0] left_o,
  output logic signed [DW-1:0] right_o,
  output logic                 valid_o,
  output logic                 zero_o,
  output logic                 busy_o
);
  logic [GW-1:0]        gain_w;
  logic signed [DW-1:0] in_w  [2];
  logic signed [DW-1:0] out_w [2];

  smz_ramp #(.STEPS(STEPS), .SPS(SPS)) u_ramp (
    .clk_i, .rst_ni, .valid_i, .mute_i,
    .gain_o(gain_w), .busy_o
  );

  assign in_w[0] = left_i;
  assign in_w[1] = right_i;

  for (genvar c = 0; c < 2; c++) begin : g_ch
    smz_scale #(.DW(DW), .STEPS(STEPS)) u_scale (
      .clk_i, .rst_ni, .valid_i,
      .gain_i(gain_w), .sample_i(in_w[c]), .sample_o(out_w[c])
    );
  end

  assign left_o  = out_w[0];
  assign right_o = out_w[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_o <= 1'b0;
    else         valid_o <= valid_i;
  end

  smz_silence #(.DW(DW), .LIMIT(ZERO_LIMIT)) u_sil (
    .clk_i, .rst_ni, .valid_i,
    .left_i(left_i), .right_i(right_i), .zero_o
  );
endmodule

// File: rtl/soft_mute_zdet_chk.sv
module soft_mute_zdet_chk #(
  parameter int DW    = 16,
  parameter int STEPS = 64,
  parameter int GW    = 7
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          valid_i,
  input logic [DW-1:0] left_i,
  input logic [DW-1:0] right_i,
  input logic          valid_o,
  input logic          zero_o,
  input logic          busy_o,
  input logic [GW-1:0] gain_w
);
  a_r3_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  a_r3_valid_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  a_r2_gain_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(gain_w) <= STEPS);
  a_r6_gain_unit_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gain_w != $past(gain_w)) |->
      (int'(gain_w) == int'($past(gain_w)) + 1 || int'(gain_w) + 1 == int'($past(gain_w))));
  a_r4_gain_moves_when_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gain_w != $past(gain_w)) |-> ($past(busy_o) && $past(valid_i)));
  a_r4_busy_ends_on_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(valid_i));
  a_r7_rise_on_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(zero_o) |-> $past(valid_i && left_i == '0 && right_i == '0));
  a_r8_nonzero_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (left_i != '0 || right_i != '0)) |=> !zero_o);
endmodule

bind soft_mute_zdet soft_mute_zdet_chk #(.DW(DW), .STEPS(STEPS), .GW(GW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i),
  .left_i(left_i), .right_i(right_i), .valid_o(valid_o),
  .zero_o(zero_o), .busy_o(busy_o), .gain_w(gain_w)
);

// File: tb/soft_mute_zdet_bench.sv
module soft_mute_zdet_bench;
  localparam int DW = 16, STEPS = 64, SPS = 16, ZL = 15435, GAP = 3;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, vld = 1'b0, mute = 1'b0;
  logic signed [DW-1:0] l_in = '0, r_in = '0;
  logic signed [DW-1:0] l_out, r_out;
  logic v_out, z_out, b_out;

  soft_mute_zdet u_soft_mute_zdet (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(vld), .left_i(l_in), .right_i(r_in),
    .mute_i(mute), .left_o(l_out), .right_o(r_out), .valid_o(v_out),
    .zero_o(z_out), .busy_o(b_out)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  int seed = 32'h1234_5677;

  // behavioural reference: dir 0 idle, 1 down, 2 up
  int m_gain = STEPS, m_dir = 0, m_sub = 0, m_cnt = 0, m_l = 0, m_r = 0, m_v = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_gain = STEPS; m_dir = 0; m_sub = 0; m_cnt = 0; m_l = 0; m_r = 0; m_v = 0;
    end else begin
      int ng, nd, ns;
      ng = m_gain; nd = m_dir; ns = m_sub;
      if (m_dir == 0) begin
        if (mute && m_gain == STEPS) begin nd = 1; ns = 0; end
        else if (!mute && m_gain == 0) begin nd = 2; ns = 0; end
      end else if (vld) begin
        if (m_sub == SPS - 1) begin
          ns = 0;
          ng = (m_dir == 1) ? m_gain - 1 : m_gain + 1;
          if (ng == 0 || ng == STEPS) nd = 0;
        end else ns = m_sub + 1;
      end
      if (vld) begin
        m_l = (int'(l_in) * m_gain) >>> 6;
        m_r = (int'(r_in) * m_gain) >>> 6;
        m_v = 1;
        if (l_in != 0 || r_in != 0) m_cnt = 0;
        else if (m_cnt < ZL) m_cnt++;
      end else m_v = 0;
      m_gain = ng; m_dir = nd; m_sub = ns;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R3 valid_o", int'(v_out), m_v);
      chk("R3 left_o", int'(l_out), m_l);
      chk("R3 right_o", int'(r_out), m_r);
      chk("R4 busy_o", int'(b_out), int'(m_dir != 0));
      chk("R7 zero_o", int'(z_out), int'(m_cnt == ZL));
    end
  end

  function automatic int rnd();
    seed ^= seed << 13; seed ^= seed >> 17; seed ^= seed << 5;
    rnd = int'($signed(seed[15:0]));
    if (rnd == 0) rnd = 1;
  endfunction

  task automatic strobe(input int l, input int r);
    @(negedge clk);
    vld = 1'b1; l_in = DW'(l); r_in = DW'(r);
    @(negedge clk);
    vld = 1'b0;
    repeat (GAP - 2) @(negedge clk);
  endtask

  task automatic noise(input int n);
    for (int i = 0; i < n; i++) strobe(rnd(), rnd());
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy_o", int'(b_out), 0);
    chk("R1 zero_o", int'(z_out), 0);
    chk("R1 valid_o", int'(v_out), 0);
    rst_n = 1'b1;
    strobe(1000, -1000);
    chk("R1 unity left", int'(l_out), 1000);
    chk("R1 unity right", int'(r_out), -1000);
    strobe(-32768, 32767);
    chk("R3 min", int'(l_out), -32768);
    chk("R3 max", int'(r_out), 32767);
    strobe(-1, 1);
    chk("R3 minus one", int'(l_out), -1);

    // R2 full ramp down
    mute = 1'b1;
    noise(1);
    chk("R4 busy after start", int'(b_out), 1);
    noise(1022);
    chk("R2 busy before last strobe", int'(b_out), 1);
    noise(1);
    chk("R2 ramp done", int'(b_out), 0);
    strobe(20000, -20000);
    chk("R2 silent", int'(l_out), 0);

    // R5 ramp up with midpoint
    mute = 1'b0;
    noise(512);
    strobe(20000, -20000);
    chk("R5 half gain", int'(l_out), 10000);
    chk("R5 half gain right", int'(r_out), -10000);
    noise(511);
    chk("R5 ramp done", int'(b_out), 0);
    strobe(12345, -7);
    chk("R5 unity", int'(l_out), 12345);

    // R6 glitch during ramp is ignored
    mute = 1'b1;
    noise(100);
    mute = 1'b0;
    noise(50);
    chk("R6 still busy", int'(b_out), 1);
    mute = 1'b1;
    noise(874);
    chk("R6 ramp ends", int'(b_out), 0);
    strobe(5000, 5000);
    chk("R6 stays muted", int'(l_out), 0);
    chk("R6 no new ramp", int'(b_out), 0);

    // R6 held change acted on after ramp
    mute = 1'b0;
    noise(200);
    mute = 1'b1;
    noise(824);
    @(negedge clk);
    chk("R6 follow-up ramp", int'(b_out), 1);
    noise(16);
    strobe(6400, 6400);
    chk("R6 stepping down", int'(l_out), 6300);

    // R7 silence window
    for (int i = 0; i < ZL - 1; i++) strobe(0, 0);
    chk("R7 one short", int'(z_out), 0);
    strobe(0, 0);
    chk("R7 rises", int'(z_out), 1);
    for (int i = 0; i < 5; i++) strobe(0, 0);
    chk("R7 saturates", int'(z_out), 1);

    // R8 clear from each channel
    strobe(0, 7);
    chk("R8 right clears", int'(z_out), 0);
    for (int i = 0; i < ZL - 1; i++) strobe(0, 0);
    chk("R8 count restarted", int'(z_out), 0);
    strobe(3, 0);
    chk("R8 left clears", int'(z_out), 0);
    strobe(0, 0);
    chk("R8 low after clear", int'(z_out), 0);

    finish_run();
  end
endmodule